// File: doc/BRIEF.md
# Queued SPI Transfer Engine with Run/Stop Control

This block moves serial frames between a four-entry transmit queue and a four-entry receive queue. In controller mode it takes one 32-bit entry at a time. The upper half of the entry is a command that gives the frame length and an end-of-queue marker, and the lower half is the payload. It then generates the serial clock and an active-low select and shifts the payload out MSB first. In responder mode it waits for an outside controller to pull the select low. It then shifts out the whole 32-bit head entry, MSB first, and collects 32 incoming bits.

A two-state RUNNING/STOPPED controller decides whether a new frame may begin. Several conditions force a stop: a halt input, a debug indication combined with a freeze enable, a latched end-of-queue flag, or a configuration field other than zero. A frame that has already begun always completes, so a stop only takes effect at a frame boundary. Both modes use the same rule. The end-of-queue flag is set when a marked frame completes and is cleared by a write-one pulse.

Top module: `qspi_engine`

## Requirements
- R1: Leaving reset the engine is STOPPED, with select high, clock low, queues empty and both flags clear. From STOPPED it moves to RUNNING on the next clock edge whenever every stop condition is absent.
- R2: The stop conditions are: the halt input is high, the debug input and the freeze enable are both high, the end-of-queue flag is set, or the configuration field is nonzero. Any one of them on its own prevents RUNNING.
- R3: When a stop condition appears while no frame is active, running_o falls on the next edge. When it appears during a frame, running_o stays high until the frame ends and falls on the edge after frame_busy_o falls.
- R4: In controller mode a frame pops the head entry, where bits [20:16] hold the length minus one and bits [15:0] hold the payload. The frame sends length bits of {16'h0, payload}, MSB first. It lasts length×DIV cycles with select low, gives one rising sclk per bit, changes mosi on falling sclk and samples miso on rising sclk.
- R5: When a controller frame with entry bit 31 set completes, the end-of-queue flag is set. A pulse on eoq_clr_i clears the flag. If the set and the clear fall in the same cycle, the set wins.
- R6: No frame starts while the transmit queue is empty. The queue holds 4 entries, and a push while it is full is ignored.
- R7: The receive queue holds 4 entries. A frame that completes while it is full is discarded and sets rx_ovf_o, which then stays set until reset.
- R8: Received controller data is right-justified in the receive entry, with the upper bits zero.
- R9: In responder mode, each falling select starts a 32-bit frame. The frame shifts out the head transmit entry (or zeros if the queue is empty) MSB first, changing on falling sclk and sampling on rising sclk. The 32 sampled bits go into the receive queue.
- R10: In responder mode the run/stop rule also applies: while STOPPED, a select and clock sequence from outside neither pushes receive data nor drives data out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Stop request |
| freeze_en_i | input | 1 | Allows debug to stop the engine |
| debug_i | input | 1 | Chip debug indication |
| cfg_i | input | 2 | Mode configuration; 0 selects SPI operation |
| master_i | input | 1 | 1 = controller mode, 0 = responder mode |
| eoq_clr_i | input | 1 | Write-one pulse that clears the end-of-queue flag |
| tx_push_i | input | 1 | Push into the transmit queue |
| tx_word_i | input | 32 | Transmit entry |
| tx_full_o | output | 1 | Transmit queue full |
| rx_pop_i | input | 1 | Pop from the receive queue |
| rx_word_o | output | 32 | Receive queue head |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_ovf_o | output | 1 | Sticky receive overflow |
| eoq_flag_o | output | 1 | End-of-queue flag |
| running_o | output | 1 | 1 = RUNNING, 0 = STOPPED |
| frame_busy_o | output | 1 | A frame is in progress |
| sclk_o | output | 1 | Controller serial clock |
| cs_n_o | output | 1 | Controller select, active low |
| mosi_o | output | 1 | Controller serial data out |
| miso_i | input | 1 | Controller serial data in |
| slv_sclk_i | input | 1 | Responder serial clock in |
| slv_cs_n_i | input | 1 | Responder select in, active low |
| slv_mosi_i | input | 1 | Responder serial data in |
| slv_miso_o | output | 1 | Responder serial data out |

## Verification
Two events can fall on the same edge. The first case is the completion of a marked frame and a software clear of the end-of-queue flag. The bench raises the clear pulse exactly in the cycle its model predicts the frame ends, and it expects the flag to remain set. The second case is a halt that arrives while a long frame is shifting. Here the bench checks every cycle that running_o holds until frame_busy_o falls and drops one edge later.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
    localparam int WORD_W   = 32;
    localparam int DATA_W   = 16;
    localparam int SIZE_LSB = 16;
    localparam int SIZE_W   = 5;
    localparam int EOQ_BIT  = 31;
    localparam int IDXW     = $clog2(WORD_W);
    localparam logic [1:0] CFG_SPI = 2'b00;

    typedef enum logic {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_e;
endpackage

// File: rtl/qspi_fifo.sv
module qspi_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] data_o,
    output logic         full_o,
    output logic         empty_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wr;
        logic [AW-1:0]           rd;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t q, d;
    logic  do_push, do_pop;

    always_comb begin
        d       = q;
        do_push = push_i && (q.cnt != CW'(DEPTH));
        do_pop  = pop_i && (q.cnt != '0);
        if (do_push) begin
            d.mem[q.wr] = data_i;
            d.wr = (q.wr == AW'(DEPTH - 1)) ? '0 : q.wr + 1'b1;
        end
        if (do_pop) begin
            d.rd = (q.rd == AW'(DEPTH - 1)) ? '0 : q.rd + 1'b1;
        end
        d.cnt = q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data_o  = q.mem[q.rd];
    assign full_o  = (q.cnt == CW'(DEPTH));
    assign empty_o = (q.cnt == '0);
endmodule

// File: rtl/qspi_runctl.sv
module qspi_runctl
    import qspi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_i,
    input  logic       freeze_en_i,
    input  logic       debug_i,
    input  logic [1:0] cfg_i,
    input  logic       frame_busy_i,
    input  logic       eoq_set_i,
    input  logic       eoq_clr_i,
    output logic       running_o,
    output logic       go_o,
    output logic       eoq_o
);
    typedef struct packed {
        run_state_e st;
        logic       eoq;
    } rc_t;

    rc_t  q, d;
    logic stop_req;

    always_comb begin
        stop_req = q.eoq | halt_i | (debug_i & freeze_en_i) | (cfg_i != CFG_SPI);
        d = q;
        if (q.st == ST_STOPPED) begin
            if (!stop_req) d.st = ST_RUNNING;
        end else begin
            if (stop_req && !frame_busy_i) d.st = ST_STOPPED;
        end
        if (eoq_set_i)      d.eoq = 1'b1;
        else if (eoq_clr_i) d.eoq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_STOPPED, eoq: 1'b0};
        else        q <= d;
    end

    assign running_o = (q.st == ST_RUNNING);
    assign go_o      = running_o && !stop_req;
    assign eoq_o     = q.eoq;

    // R3
    stop_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running_o) |-> !$past(frame_busy_i));
endmodule

// File: rtl/qspi_shifter.sv
module qspi_shifter
    import qspi_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_i,
    input  logic              go_i,
    input  logic              tx_avail_i,
    input  logic [WORD_W-1:0] tx_word_i,
    output logic              tx_pop_o,
    output logic              rx_push_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              busy_o,
    output logic              eoq_hit_o,
    output logic              sclk_o,
    output logic              cs_n_o,
    output logic              mosi_o,
    input  logic              miso_i,
    input  logic              s_sclk_i,
    input  logic              s_cs_n_i,
    input  logic              s_mosi_i,
    output logic              s_miso_o
);
    localparam int HALF = DIV / 2;
    localparam int DCW  = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [IDXW-1:0] IDX_MAX = IDXW'(WORD_W - 1);

    typedef struct packed {
        logic              busy;
        logic              slave;
        logic              sclk;
        logic [DCW-1:0]    div;
        logic [IDXW-1:0]   idx;
        logic              eoq;
        logic [WORD_W-1:0] tx_sh;
        logic [WORD_W-1:0] rx_sh;
        logic [2:0]        ssclk;
        logic [2:0]        scs;
        logic [1:0]        smosi;
    } sh_t;

    sh_t               q, d;
    logic [SIZE_W-1:0] size;
    logic [WORD_W-1:0] padded;
    logic              s_rise, s_fall, cs_fall, cs_rise;

    always_comb begin
        d         = q;
        tx_pop_o  = 1'b0;
        rx_push_o = 1'b0;
        eoq_hit_o = 1'b0;
        rx_word_o = q.rx_sh;
        size      = tx_word_i[SIZE_LSB +: SIZE_W];
        padded    = WORD_W'(tx_word_i[DATA_W-1:0]);
        s_rise    = q.ssclk[1] & ~q.ssclk[2];
        s_fall    = ~q.ssclk[1] & q.ssclk[2];
        cs_fall   = ~q.scs[1] & q.scs[2];
        cs_rise   = q.scs[1] & ~q.scs[2];
        d.ssclk   = {q.ssclk[1:0], s_sclk_i};
        d.scs     = {q.scs[1:0], s_cs_n_i};
        d.smosi   = {q.smosi[0], s_mosi_i};

        if (!q.busy) begin
            if (go_i && master_i && tx_avail_i) begin
                tx_pop_o = 1'b1;
                d.busy   = 1'b1;
                d.slave  = 1'b0;
                d.sclk   = 1'b0;
                d.div    = '0;
                d.idx    = size;
                d.eoq    = tx_word_i[EOQ_BIT];
                d.tx_sh  = padded << (IDX_MAX - size);
                d.rx_sh  = '0;
            end else if (go_i && !master_i && cs_fall) begin
                tx_pop_o = tx_avail_i;
                d.busy   = 1'b1;
                d.slave  = 1'b1;
                d.idx    = '0;
                d.eoq    = 1'b0;
                d.tx_sh  = tx_avail_i ? tx_word_i : '0;
                d.rx_sh  = '0;
            end
        end else if (!q.slave) begin
            if (q.div == DCW'(HALF - 1)) begin
                d.div  = '0;
                d.sclk = ~q.sclk;
                if (!q.sclk) begin
                    d.rx_sh = {q.rx_sh[WORD_W-2:0], miso_i};
                end else if (q.idx == '0) begin
                    d.busy    = 1'b0;
                    rx_push_o = 1'b1;
                    eoq_hit_o = q.eoq;
                end else begin
                    d.idx   = q.idx - 1'b1;
                    d.tx_sh = {q.tx_sh[WORD_W-2:0], 1'b0};
                end
            end else begin
                d.div = q.div + 1'b1;
            end
        end else begin
            if (cs_rise) begin
                d.busy = 1'b0;
            end else if (s_rise) begin
                d.rx_sh = {q.rx_sh[WORD_W-2:0], q.smosi[1]};
                if (q.idx == IDX_MAX) begin
                    d.busy    = 1'b0;
                    rx_push_o = 1'b1;
                    rx_word_o = d.rx_sh;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end else if (s_fall) begin
                d.tx_sh = {q.tx_sh[WORD_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.scs   <= '1;
        end else begin
            q <= d;
        end
    end

    assign busy_o   = q.busy;
    assign sclk_o   = q.sclk & q.busy & ~q.slave;
    assign cs_n_o   = ~(q.busy & ~q.slave);
    assign mosi_o   = q.busy & ~q.slave & q.tx_sh[WORD_W-1];
    assign s_miso_o = q.busy & q.slave & q.tx_sh[WORD_W-1];
endmodule

// File: rtl/qspi_engine.sv
module qspi_engine
    import qspi_pkg::*;
#(
    parameter int DIV        = 4,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_i,
    input  logic              freeze_en_i,
    input  logic              debug_i,
    input  logic [1:0]        cfg_i,
    input  logic              master_i,
    input  logic              eoq_clr_i,
    input  logic              tx_push_i,
    input  logic [WORD_W-1:0] tx_word_i,
    output logic              tx_full_o,
    input  logic              rx_pop_i,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_empty_o,
    output logic              rx_ovf_o,
    output logic              eoq_flag_o,
    output logic              running_o,
    output logic              frame_busy_o,
    output logic              sclk_o,
    output logic              cs_n_o,
    output logic              mosi_o,
    input  logic              miso_i,
    input  logic              slv_sclk_i,
    input  logic              slv_cs_n_i,
    input  logic              slv_mosi_i,
    output logic              slv_miso_o
);
    typedef struct packed {
        logic ovf;
    } top_t;

    top_t              q, d;
    logic [WORD_W-1:0] tx_head, rx_in;
    logic              tx_empty, tx_pop, rx_push, rx_full, go, eoq_hit;

    qspi_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push_i(tx_push_i), .data_i(tx_word_i),
        .pop_i(tx_pop), .data_o(tx_head), .full_o(tx_full_o), .empty_o(tx_empty));

    qspi_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push_i(rx_push), .data_i(rx_in),
        .pop_i(rx_pop_i), .data_o(rx_word_o), .full_o(rx_full), .empty_o(rx_empty_o));

    qspi_runctl u_ctl (
        .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .freeze_en_i(freeze_en_i),
        .debug_i(debug_i), .cfg_i(cfg_i), .frame_busy_i(frame_busy_o),
        .eoq_set_i(eoq_hit), .eoq_clr_i(eoq_clr_i), .running_o(running_o),
        .go_o(go), .eoq_o(eoq_flag_o));

    qspi_shifter #(.DIV(DIV)) u_sh (
        .clk(clk), .rst_n(rst_n), .master_i(master_i), .go_i(go),
        .tx_avail_i(!tx_empty), .tx_word_i(tx_head), .tx_pop_o(tx_pop),
        .rx_push_o(rx_push), .rx_word_o(rx_in), .busy_o(frame_busy_o),
        .eoq_hit_o(eoq_hit), .sclk_o(sclk_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o),
        .miso_i(miso_i), .s_sclk_i(slv_sclk_i), .s_cs_n_i(slv_cs_n_i),
        .s_mosi_i(slv_mosi_i), .s_miso_o(slv_miso_o));

    always_comb begin
        d = q;
        if (rx_push && rx_full) d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_ovf_o = q.ovf;

    // R1
    start_when_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_busy_o) |-> $past(running_o));
    // R5
    eoq_on_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoq_flag_o) |-> $fell(frame_busy_o));
    // R6
    no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);
    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf_o |=> rx_ovf_o);
endmodule

// File: tb/qspi_engine_test.sv
module qspi_engine_test;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt = 1'b1, frz = 1'b0, dbg = 1'b0, master = 1'b1, clr = 1'b0;
    logic [1:0]  cfg = 2'b00;
    logic        tx_push = 1'b0, rx_pop = 1'b0;
    logic [31:0] tx_din = '0;
    logic        s_sclk = 1'b0, s_cs_n = 1'b1, s_mosi = 1'b0;
    logic        miso_ones = 1'b0;
    logic        tx_full, rx_empty, rx_ovf, eoq_flag, running, busy;
    logic        sclk, cs_n, mosi, miso, s_miso;
    logic [31:0] rx_word;

    int nchk = 0, nerr = 0;
    bit model_on = 1'b0;

    always #4 clk = ~clk;
    assign miso = miso_ones ? 1'b1 : mosi;

    qspi_engine #(.DIV(DIV), .FIFO_DEPTH(4)) uut (
        .clk(clk), .rst_n(rst_n), .halt_i(halt), .freeze_en_i(frz), .debug_i(dbg),
        .cfg_i(cfg), .master_i(master), .eoq_clr_i(clr), .tx_push_i(tx_push),
        .tx_word_i(tx_din), .tx_full_o(tx_full), .rx_pop_i(rx_pop), .rx_word_o(rx_word),
        .rx_empty_o(rx_empty), .rx_ovf_o(rx_ovf), .eoq_flag_o(eoq_flag),
        .running_o(running), .frame_busy_o(busy), .sclk_o(sclk), .cs_n_o(cs_n),
        .mosi_o(mosi), .miso_i(miso), .slv_sclk_i(s_sclk), .slv_cs_n_i(s_cs_n),
        .slv_mosi_i(s_mosi), .slv_miso_o(s_miso));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit e, input int size, input logic [15:0] data);
        return {e, 10'd0, 5'(size), data};
    endfunction

    function automatic logic [31:0] expf(input int size, input logic [15:0] data, input bit ones);
        logic [63:0] mask = (64'd1 << (size + 1)) - 64'd1;
        return ones ? mask[31:0] : ({16'd0, data} & mask[31:0]);
    endfunction

    // behavioural reference model
    logic [31:0] txq[$], rxq[$];
    bit m_run, m_busy, m_eoq, m_ovf, m_eoqbit;
    int m_cnt, m_len, m_bit;
    logic [31:0] m_word, m_exp;

    always @(posedge clk) begin
        int old_tx, old_rx, sz;
        bit stop, start, n_run, set_eoq;
        logic [31:0] w;
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            m_run = 0; m_busy = 0; m_eoq = 0; m_ovf = 0; m_cnt = 0;
        end else if (model_on) begin
            old_tx = txq.size(); old_rx = rxq.size();
            stop = m_eoq || halt || (dbg && frz) || (cfg != 2'b00);
            n_run = m_run ? !(stop && !m_busy) : !stop;
            start = m_run && !stop && !m_busy && master && (old_tx > 0);
            set_eoq = 0;
            if (rx_pop && old_rx > 0) void'(rxq.pop_front());
            if (start) begin
                w = txq.pop_front();
                sz = int'(w[20:16]);
                m_busy = 1; m_cnt = (sz + 1) * DIV; m_len = sz + 1; m_bit = sz;
                m_word = {16'd0, w[15:0]}; m_eoqbit = w[31];
                m_exp = expf(sz, w[15:0], miso_ones);
            end else if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 0;
                    if (old_rx < 4) rxq.push_back(m_exp); else m_ovf = 1;
                    if (m_eoqbit) begin m_eoq = 1; set_eoq = 1; end
                end
            end
            if (clr && !set_eoq) m_eoq = 0;
            if (tx_push && old_tx < 4) txq.push_back(tx_din);
            m_run = n_run;
        end
    end

    // every-cycle comparison and serial monitor
    logic sclk_prev = 1'b0, busy_prev = 1'b0;
    int rises = 0;
    always @(negedge clk) begin
        if (rst_n && model_on) begin
            chk(running == m_run, "R3", "running per cycle", 32'(running), 32'(m_run));
            chk(eoq_flag == m_eoq, "R5", "eoq per cycle", 32'(eoq_flag), 32'(m_eoq));
            chk(busy == m_busy, "R4", "busy per cycle", 32'(busy), 32'(m_busy));
            chk(cs_n == !m_busy, "R4", "select per cycle", 32'(cs_n), 32'(!m_busy));
            chk(tx_full == (txq.size() == 4), "R6", "tx full per cycle", 32'(tx_full), 32'(txq.size() == 4));
            chk(rx_empty == (rxq.size() == 0), "R7", "rx empty per cycle", 32'(rx_empty), 32'(rxq.size() == 0));
            chk(rx_ovf == m_ovf, "R7", "ovf per cycle", 32'(rx_ovf), 32'(m_ovf));
            if (sclk && !sclk_prev) begin
                chk(mosi == m_word[m_bit], "R4", "mosi bit at rising sclk", 32'(mosi), 32'(m_word[m_bit]));
                m_bit--; rises++;
            end
            if (busy_prev && !busy) begin
                chk(rises == m_len, "R4", "rising sclk count", 32'(rises), 32'(m_len));
                rises = 0;
            end
        end
        sclk_prev = sclk; busy_prev = busy;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [31:0] w);
        tx_push = 1; tx_din = w; @(negedge clk); tx_push = 0;
    endtask

    task automatic pop_chk(input logic [31:0] exp, input string req);
        chk(!rx_empty, req, "rx entry present", 32'(rx_empty), 32'd0);
        chk(rx_word == exp, req, "rx data", rx_word, exp);
        rx_pop = 1; @(negedge clk); rx_pop = 0;
    endtask

    task automatic wait_idle();
        tick(1);
        while (m_busy || (txq.size() > 0 && m_run)) @(negedge clk);
        tick(2);
    endtask

    task automatic slave_frame(input logic [31:0] mdata, output logic [31:0] got);
        s_cs_n = 0; tick(8);
        for (int i = 31; i >= 0; i--) begin
            s_mosi = mdata[i]; tick(8);
            got[i] = s_miso; s_sclk = 1; tick(8); s_sclk = 0;
        end
        tick(8); s_cs_n = 1; tick(8);
    endtask

    initial begin
        logic [31:0] got;
        tick(5);
        rst_n = 1; model_on = 1;
        tick(1);
        // R1 reset state
        chk(running == 0, "R1", "reset running", 32'(running), 0);
        chk(cs_n == 1 && sclk == 0, "R1", "reset select/clock", {cs_n, sclk}, 32'b10);
        chk(rx_empty && !tx_full && !eoq_flag && !rx_ovf, "R1", "reset flags",
            {rx_empty, tx_full, eoq_flag, rx_ovf}, 32'b1000);
        // R1 start
        halt = 0; tick(2);
        chk(running == 1, "R1", "running after halt released", 32'(running), 1);
        // R4 R8 several frames
        push(mk(0, 7, 16'h00A5)); push(mk(0, 15, 16'h1234));
        push(mk(0, 0, 16'h0001)); push(mk(0, 20, 16'hBEEF));
        wait_idle();
        pop_chk(expf(7, 16'h00A5, 0), "R8");
        pop_chk(expf(15, 16'h1234, 0), "R4");
        pop_chk(expf(0, 16'h0001, 0), "R4");
        pop_chk(expf(20, 16'hBEEF, 0), "R8");
        miso_ones = 1; push(mk(0, 11, 16'h0000)); wait_idle();
        pop_chk(expf(11, 16'h0, 1), "R8"); miso_ones = 0;
        // R6 empty queue
        tick(20);
        chk(busy == 0 && cs_n == 1, "R6", "no frame with empty tx", 32'(busy), 0);
        // R6 full queue
        halt = 1; tick(2);
        for (int i = 0; i < 5; i++) push(mk(0, 3, 16'(i + 1)));
        chk(tx_full == 1, "R6", "tx full after 4 pushes", 32'(tx_full), 1);
        halt = 0; wait_idle();
        for (int i = 0; i < 4; i++) pop_chk(expf(3, 16'(i + 1), 0), "R6");
        chk(rx_empty == 1, "R6", "fifth push ignored", 32'(rx_empty), 1);
        // R3 halt mid-frame
        push(mk(0, 31, 16'hC0DE));
        while (!busy) @(negedge clk);
        tick(10); halt = 1; tick(1);
        chk(running == 1, "R3", "running held during frame", 32'(running), 1);
        while (busy) @(negedge clk);
        chk(running == 1, "R3", "running at frame end edge", 32'(running), 1);
        tick(1);
        chk(running == 0, "R3", "stopped after frame", 32'(running), 0);
        pop_chk(expf(31, 16'hC0DE, 0), "R4");
        halt = 0; tick(2);
        halt = 1; tick(1);
        chk(running == 0, "R3", "idle stop immediate", 32'(running), 0);
        halt = 0; tick(2);
        // R2 debug and freeze
        dbg = 1; tick(2);
        chk(running == 1, "R2", "debug without freeze", 32'(running), 1);
        frz = 1; tick(2);
        chk(running == 0, "R2", "debug with freeze", 32'(running), 0);
        dbg = 0; tick(2);
        chk(running == 1, "R1", "restart after debug", 32'(running), 1);
        frz = 0;
        // R2 configuration field
        cfg = 2'b10; tick(2);
        chk(running == 0, "R2", "nonzero cfg stops", 32'(running), 0);
        push(mk(0, 4, 16'h0015)); tick(20);
        chk(busy == 0 && rx_empty, "R2", "no frame while cfg nonzero", 32'(busy), 0);
        cfg = 2'b00; wait_idle();
        pop_chk(expf(4, 16'h0015, 0), "R2");
        // R5 end of queue
        push(mk(1, 3, 16'h0009)); push(mk(0, 3, 16'h0006));
        while (!m_eoq) @(negedge clk);
        chk(eoq_flag == 1, "R5", "eoq set at frame end", 32'(eoq_flag), 1);
        tick(3);
        chk(running == 0 && busy == 0, "R5", "stopped by eoq", {running, busy}, 0);
        tick(10);
        pop_chk(expf(3, 16'h0009, 0), "R5");
        chk(rx_empty == 1, "R5", "next frame held", 32'(rx_empty), 1);
        clr = 1; @(negedge clk); clr = 0;
        chk(eoq_flag == 0, "R5", "eoq cleared", 32'(eoq_flag), 0);
        wait_idle();
        pop_chk(expf(3, 16'h0006, 0), "R5");
        // R5 set and clear in the same cycle
        push(mk(1, 2, 16'h0005));
        tick(1);
        while (!(m_busy && m_cnt == 1)) @(negedge clk);
        clr = 1; @(negedge clk); clr = 0;
        chk(eoq_flag == 1, "R5", "set wins over clear", 32'(eoq_flag), 1);
        clr = 1; @(negedge clk); clr = 0;
        pop_chk(expf(2, 16'h0005, 0), "R5");
        wait_idle();
        // R7 overflow
        halt = 1; tick(2);
        for (int i = 0; i < 4; i++) push(mk(0, 1, 16'(i)));
        halt = 0; wait_idle();
        push(mk(0, 1, 16'h0003)); wait_idle();
        chk(rx_ovf == 1, "R7", "overflow flagged", 32'(rx_ovf), 1);
        for (int i = 0; i < 4; i++) pop_chk(expf(1, 16'(i), 0), "R7");
        chk(rx_empty == 1 && rx_ovf == 1, "R7", "dropped frame, sticky flag", {rx_empty, rx_ovf}, 32'b11);
        // R9 responder mode
        model_on = 0; master = 0; tick(2);
        push(32'hC3A5_0F96); tick(2);
        slave_frame(32'h1234_ABCD, got);
        chk(got == 32'hC3A5_0F96, "R9", "responder out bits", got, 32'hC3A5_0F96);
        chk(cs_n == 1 && sclk == 0, "R9", "controller pins idle", {cs_n, sclk}, 32'b10);
        pop_chk(32'h1234_ABCD, "R9");
        slave_frame(32'h8000_0001, got);
        chk(got == 32'h0, "R9", "zeros with empty tx", got, 0);
        pop_chk(32'h8000_0001, "R9");
        // R10 responder ignored while stopped
        halt = 1; tick(3);
        push(32'hFFFF_FFFF); tick(2);
        slave_frame(32'h5555_AAAA, got);
        chk(rx_empty == 1, "R10", "no receive while stopped", 32'(rx_empty), 1);
        chk(got == 32'h0, "R10", "no drive while stopped", got, 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule